// File: doc/BRIEF.md
# Floating-Point Normalize and Round Unit

This unit is the back end of a single-precision adder. The alignment and add stages hand it a raw significand sum with a carry-out bit, three extension bits (guard, round, sticky), an exponent not yet adjusted, and the result sign. The unit returns a finished, packed binary32 word.

It first brings the sum back to the form 1.xxx. A carried sum moves one place right. A sum that lost leading ones through cancellation moves left by the number of leading zeros. The exponent follows the shift in both cases. It then rounds to 23 fraction bits under one of four modes chosen per operation, and fixes the result again if the rounding increment rippled past the top bit. Exponents that leave the representable range are reported on two flag outputs and produce signed infinity or signed zero. Subnormal results are not produced: any result too small to be normal is flushed to zero.

The unit accepts one operation per clock and answers two clocks later.

Top module: `fpnr_unit`

## Requirements
- R1: A result appears on `out_valid` exactly two rising edges after the edge that samples `in_valid`, one operation per cycle.
- R2: When `in_carry` is 1, the significand moves one place right and the exponent rises by one. The old significand LSB becomes the new guard bit, the old guard becomes the round bit, and the OR of the old round and sticky bits becomes the sticky bit.
- R3: When `in_carry` is 0, the vector {significand, guard, round} is shifted left until its top bit is 1, and the exponent drops by the shift amount. The guard and then the round bit enter from the right, and the sticky bit keeps its role.
- R4: Mode 00 (nearest, ties to even) increments the significand when the guard bit is 1 and at least one of round, sticky or the kept LSB is 1.
- R5: Mode 01 (truncate) never increments the significand.
- R6: Mode 10 (toward +infinity) increments when the sign is 0 and any of guard, round or sticky is 1. Mode 11 (toward -infinity) does the same when the sign is 1.
- R7: When the rounding increment carries out of the 24-bit significand, the significand becomes 1.0 and the exponent rises by one.
- R8: A biased exponent of 255 or more, either after normalization or after R7, gives infinity with the result sign: exponent field all ones, fraction 0, and `out_ovf` = 1.
- R9: A biased exponent of 0 or less after normalization, or a nonzero sum with only the sticky bit set, gives zero with the result sign and `out_unf` = 1.
- R10: A sum that is exactly zero (carry, significand, guard, round and sticky all 0) gives -0 in mode 11 and +0 in every other mode, with both flags 0.
- R11: While `rst` is high the outputs `out_valid`, `out_result`, `out_ovf` and `out_unf` are all 0.
- R12: `out_ovf` and `out_unf` are never 1 together, and neither is 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_sign | input | 1 | Sign of the sum |
| in_carry | input | 1 | Carry out of the significand addition |
| in_sig | input | MAN_W+1 | Raw significand sum, integer bit at the top |
| in_guard | input | 1 | First bit below the significand LSB |
| in_round | input | 1 | Second bit below the significand LSB |
| in_sticky | input | 1 | OR of all lower bits |
| in_exp | input | EXP_W+2 | Biased exponent before normalization, two's complement |
| in_mode | input | 2 | Rounding mode (00 nearest-even, 01 truncate, 10 up, 11 down) |
| out_valid | output | 1 | Result valid |
| out_result | output | 1+EXP_W+MAN_W | Packed sign, exponent, fraction |
| out_ovf | output | 1 | Exponent overflow occurred |
| out_unf | output | 1 | Exponent underflow or flush occurred |

## Verification
The bench builds the unit with its defaults, MAN_W=23 and EXP_W=8, so every result can be compared with a binary32 pattern computed by hand-checkable rules. The exponent input is two bits wider than the field, which lets directed cases push the normalized exponent above 255 and below 1. The bench can therefore reach both flag paths, as well as the carry of a rounding increment into an overflow. With the default 24-bit significand, left shifts of every length up to 25 places are reachable, including shifts that pull the guard and round bits into the fraction.

// File: rtl/fpnr_pkg.sv
package fpnr_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_CHOP      = 2'b01,
    RND_POS       = 2'b10,
    RND_NEG       = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/fpnr_lzc.sv
module fpnr_lzc #(
  parameter  int W  = 26,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          none
);

  // one-hot marker of the highest set bit, built bit by bit
  logic [W-1:0] above;
  logic [W-1:0] first;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_scan
      if (gi == W - 1) begin : g_top
        assign above[gi] = 1'b0;
      end else begin : g_rest
        assign above[gi] = above[gi+1] | vec[gi+1];
      end
      assign first[gi] = vec[gi] & ~above[gi];
    end
  endgenerate

  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (first[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign none = ~|vec;

endmodule

// File: rtl/fpnr_norm.sv
module fpnr_norm #(
  parameter  int MAN_W = 23,
  parameter  int EXP_W = 8,
  localparam int SIG_W = MAN_W + 1,
  localparam int EI_W  = EXP_W + 2,
  localparam int EN_W  = EXP_W + 3
) (
  input  logic                   carry,
  input  logic [SIG_W-1:0]       sig,
  input  logic                   g,
  input  logic                   r,
  input  logic                   s,
  input  logic signed [EI_W-1:0] exp_in,
  output logic [SIG_W-1:0]       sig_n,
  output logic                   g_n,
  output logic                   r_n,
  output logic                   s_n,
  output logic signed [EN_W-1:0] exp_n,
  output logic                   zero,
  output logic                   tiny
);

  localparam int XW = SIG_W + 2;
  localparam int CW = $clog2(XW + 1);

  logic [XW-1:0]          ext;
  logic [XW-1:0]          ext_sh;
  logic [CW-1:0]          lz;
  logic                   none;
  logic signed [EN_W-1:0] exp_x;

  assign ext   = {sig, g, r};
  assign exp_x = EN_W'(exp_in);

  fpnr_lzc #(.W(XW)) u_lzc (
    .vec  (ext),
    .cnt  (lz),
    .none (none)
  );

  assign ext_sh = ext << lz;

  always_comb begin
    if (carry) begin
      // one place right: LSB -> guard, guard -> round, round|sticky -> sticky
      sig_n = {1'b1, sig[SIG_W-1:1]};
      g_n   = sig[0];
      r_n   = g;
      s_n   = r | s;
      exp_n = exp_x + EN_W'(1);
    end else begin
      // left by leading zeros; sticky keeps its place
      sig_n = ext_sh[XW-1:2];
      g_n   = ext_sh[1];
      r_n   = ext_sh[0];
      s_n   = s;
      exp_n = exp_x - EN_W'(lz);
    end
  end

  assign zero = ~carry & none & ~s;
  assign tiny = ~carry & none & s;

endmodule

// File: rtl/fpnr_round.sv
module fpnr_round
  import fpnr_pkg::*;
#(
  parameter  int MAN_W = 23,
  parameter  int EXP_W = 8,
  localparam int SIG_W = MAN_W + 1,
  localparam int EN_W  = EXP_W + 3
) (
  input  logic                   sign,
  input  rnd_mode_e              mode,
  input  logic [SIG_W-1:0]       sig_n,
  input  logic                   g,
  input  logic                   r,
  input  logic                   s,
  input  logic signed [EN_W-1:0] exp_n,
  output logic [SIG_W-1:0]       sig_r,
  output logic signed [EN_W-1:0] exp_r
);

  logic           lost;
  logic           up;
  logic [SIG_W:0] sum;

  assign lost = g | r | s;

  always_comb begin
    case (mode)
      RND_NEAR_EVEN: up = g & (r | s | sig_n[0]);
      RND_CHOP:      up = 1'b0;
      RND_POS:       up = ~sign & lost;
      default:       up = sign & lost;
    endcase
  end

  assign sum = {1'b0, sig_n} + (SIG_W + 1)'(up);

  always_comb begin
    if (sum[SIG_W]) begin
      sig_r = sum[SIG_W:1];
      exp_r = exp_n + EN_W'(1);
    end else begin
      sig_r = sum[SIG_W-1:0];
      exp_r = exp_n;
    end
  end

endmodule

// File: rtl/fpnr_unit.sv
module fpnr_unit
  import fpnr_pkg::*;
#(
  parameter  int MAN_W = 23,
  parameter  int EXP_W = 8,
  localparam int SIG_W = MAN_W + 1,
  localparam int EI_W  = EXP_W + 2,
  localparam int EN_W  = EXP_W + 3,
  localparam int FP_W  = 1 + EXP_W + MAN_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_sign,
  input  logic                   in_carry,
  input  logic [SIG_W-1:0]       in_sig,
  input  logic                   in_guard,
  input  logic                   in_round,
  input  logic                   in_sticky,
  input  logic signed [EI_W-1:0] in_exp,
  input  logic [1:0]             in_mode,
  output logic                   out_valid,
  output logic [FP_W-1:0]        out_result,
  output logic                   out_ovf,
  output logic                   out_unf
);

  localparam logic signed [EN_W-1:0] E_ZERO = '0;
  localparam logic signed [EN_W-1:0] E_MAX  = EN_W'((1 << EXP_W) - 1);

  // ---------------- stage 1: normalize ----------------
  logic [SIG_W-1:0]       n_sig;
  logic                   n_g, n_r, n_s;
  logic signed [EN_W-1:0] n_exp;
  logic                   n_zero, n_tiny;
  logic                   n_uf, n_of;

  fpnr_norm #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_norm (
    .carry  (in_carry),
    .sig    (in_sig),
    .g      (in_guard),
    .r      (in_round),
    .s      (in_sticky),
    .exp_in (in_exp),
    .sig_n  (n_sig),
    .g_n    (n_g),
    .r_n    (n_r),
    .s_n    (n_s),
    .exp_n  (n_exp),
    .zero   (n_zero),
    .tiny   (n_tiny)
  );

  assign n_uf = n_tiny | (~n_zero & (n_exp <= E_ZERO));
  assign n_of = ~n_zero & ~n_tiny & (n_exp >= E_MAX);

  logic                   s1_valid;
  logic                   s1_sign;
  rnd_mode_e              s1_mode;
  logic [SIG_W-1:0]       s1_sig;
  logic                   s1_g, s1_r, s1_s;
  logic signed [EN_W-1:0] s1_exp;
  logic                   s1_zero, s1_uf, s1_of;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    s1_sign <= in_sign;
    s1_mode <= rnd_mode_e'(in_mode);
    s1_sig  <= n_sig;
    s1_g    <= n_g;
    s1_r    <= n_r;
    s1_s    <= n_s;
    s1_exp  <= n_exp;
    s1_zero <= n_zero;
    s1_uf   <= n_uf;
    s1_of   <= n_of;
  end

  // ---------------- stage 2: round and pack ----------------
  logic [SIG_W-1:0]       r_sig;
  logic signed [EN_W-1:0] r_exp;
  logic                   of2;
  logic [FP_W-1:0]        res_d;

  fpnr_round #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_round (
    .sign  (s1_sign),
    .mode  (s1_mode),
    .sig_n (s1_sig),
    .g     (s1_g),
    .r     (s1_r),
    .s     (s1_s),
    .exp_n (s1_exp),
    .sig_r (r_sig),
    .exp_r (r_exp)
  );

  assign of2 = s1_of | (~s1_uf & ~s1_zero & (r_exp >= E_MAX));

  always_comb begin
    if (s1_zero) begin
      res_d = {(s1_mode == RND_NEG), {(FP_W - 1){1'b0}}};
    end else if (s1_uf) begin
      res_d = {s1_sign, {(FP_W - 1){1'b0}}};
    end else if (of2) begin
      res_d = {s1_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else begin
      res_d = {s1_sign, r_exp[EXP_W-1:0], r_sig[MAN_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      out_unf    <= 1'b0;
    end else begin
      out_valid  <= s1_valid;
      out_result <= res_d;
      out_ovf    <= s1_valid & of2 & ~s1_zero & ~s1_uf;
      out_unf    <= s1_valid & s1_uf;
    end
  end

  // ---------------- assertions ----------------
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  p_norm_msb_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_zero && !s1_uf && !s1_of) |-> s1_sig[SIG_W-1]);

  p_ovf_inf_r8: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_result[FP_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ovf) |-> (out_result[FP_W-2:MAN_W] != {EXP_W{1'b1}}));

  p_unf_zero_r9: assert property (@(posedge clk) disable iff (rst)
    out_unf |-> (out_result[FP_W-2:0] == '0));

  p_flag_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(out_ovf && out_unf));

  p_flag_gate_r12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_ovf && !out_unf));

endmodule

// File: tb/sim_fpnr_unit.sv
module sim_fpnr_unit;

  localparam int CLK_PERIOD = 10;
  localparam int MAN_W = 23;
  localparam int EXP_W = 8;
  localparam int SIG_W = MAN_W + 1;
  localparam int EI_W  = EXP_W + 2;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_valid = 1'b0;
  logic                   in_sign = 1'b0;
  logic                   in_carry = 1'b0;
  logic [SIG_W-1:0]       in_sig = '0;
  logic                   in_guard = 1'b0;
  logic                   in_round = 1'b0;
  logic                   in_sticky = 1'b0;
  logic signed [EI_W-1:0] in_exp = '0;
  logic [1:0]             in_mode = 2'b00;
  logic                   out_valid;
  logic [31:0]            out_result;
  logic                   out_ovf;
  logic                   out_unf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fpnr_unit #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u0 (
    .clk, .rst, .in_valid, .in_sign, .in_carry, .in_sig,
    .in_guard, .in_round, .in_sticky, .in_exp, .in_mode,
    .out_valid, .out_result, .out_ovf, .out_unf
  );

  // expected {ovf, unf, result} from the requirement rules
  function automatic logic [33:0] model(input logic sg, input logic c,
      input logic [23:0] sig, input logic g, input logic r, input logic s,
      input int e, input logic [1:0] md);
    logic [26:0] v;
    logic [26:0] a;
    logic [24:0] k;
    logic        half, rest, up;
    int          p;
    int          en;
    v = {c, sig, g, r};
    p = -1;
    for (int i = 0; i < 27; i++) if (v[i]) p = i;
    if (p < 0) begin
      if (!s) return {2'b00, (md == 2'b11), 31'd0};   // R10
      return {2'b01, sg, 31'd0};                      // R9 sticky only
    end
    en = e + p - 25;
    if (en >= 255) return {2'b10, sg, 8'hFF, 23'd0};  // R8
    if (en <= 0) return {2'b01, sg, 31'd0};           // R9
    a    = v << (26 - p);
    k    = {1'b0, a[26:3]};
    half = a[2];
    rest = a[1] | a[0] | s;
    case (md)
      2'b00:   up = half & (rest | k[0]);
      2'b01:   up = 1'b0;
      2'b10:   up = !sg & (half | rest);
      default: up = sg & (half | rest);
    endcase
    k = k + 25'(up);
    if (k[24]) begin
      k  = k >> 1;
      en = en + 1;
    end
    if (en >= 255) return {2'b10, sg, 8'hFF, 23'd0};
    return {2'b00, sg, 8'(en), k[22:0]};
  endfunction

  task automatic drive(input string tag, input logic sg, input logic c,
      input logic [23:0] sig, input logic g, input logic r, input logic s,
      input int e, input logic [1:0] md);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sign   = sg;
    in_carry  = c;
    in_sig    = sig;
    in_guard  = g;
    in_round  = r;
    in_sticky = s;
    in_exp    = EI_W'(e);
    in_mode   = md;
    exp_q.push_back(model(sg, c, sig, g, r, s, e, md));
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  logic [33:0] mon_exp;
  string       mon_tag;
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 output with nothing pending: got=%h exp=none",
                 {out_ovf, out_unf, out_result});
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        if ({out_ovf, out_unf, out_result} !== mon_exp) begin
          errors++;
          $display("FAIL %s got=%h exp=%h", mon_tag,
                   {out_ovf, out_unf, out_result}, mon_exp);
        end
      end
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd0 || out_ovf !== 1'b0 || out_unf !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs got=%b_%h_%b%b exp=0_00000000_00",
               out_valid, out_result, out_ovf, out_unf);
    end
    rst = 1'b0;
    @(negedge clk);

    drive("R4 exact 1.5",               0, 0, 24'hC00000, 0, 0, 0, 127, 2'b00);
    drive("R2 carry shift",             0, 1, 24'h800001, 0, 0, 0, 127, 2'b00);
    drive("R2 guard remap no round",    0, 1, 24'h000002, 1, 0, 0, 127, 2'b00);
    drive("R2 lsb into guard rounds",   1, 1, 24'h000003, 0, 0, 0, 130, 2'b00);
    drive("R3 left shift",              0, 0, 24'h001234, 1, 1, 0, 140, 2'b00);
    drive("R3 shift past guard",        1, 0, 24'h000000, 1, 1, 0, 127, 2'b01);
    drive("R3 one place",               0, 0, 24'h400001, 0, 1, 1, 127, 2'b00);
    drive("R4 tie even stays",          0, 0, 24'h800000, 1, 0, 0, 127, 2'b00);
    drive("R4 tie odd rounds",          0, 0, 24'h800001, 1, 0, 0, 127, 2'b00);
    drive("R4 above half rounds",       0, 0, 24'h800000, 1, 0, 1, 127, 2'b00);
    drive("R4 below half stays",        0, 0, 24'h800001, 0, 1, 1, 127, 2'b00);
    drive("R5 truncate drops",          0, 0, 24'h800001, 1, 1, 1, 127, 2'b01);
    drive("R6 up positive",             0, 0, 24'h800000, 0, 0, 1, 127, 2'b10);
    drive("R6 up negative",             1, 0, 24'h800000, 0, 0, 1, 127, 2'b10);
    drive("R6 down negative",           1, 0, 24'h800000, 0, 1, 0, 127, 2'b11);
    drive("R6 down positive",           0, 0, 24'h800000, 1, 1, 1, 127, 2'b11);
    drive("R7 round carry",             0, 0, 24'hFFFFFF, 1, 1, 0, 127, 2'b00);
    drive("R7 round carry after shift", 1, 1, 24'hFFFFFF, 1, 0, 0, 100, 2'b11);
    drive("R8 round into overflow",     0, 0, 24'hFFFFFF, 1, 0, 0, 254, 2'b00);
    drive("R8 carry overflow",          1, 1, 24'h800000, 0, 0, 0, 254, 2'b00);
    drive("R8 large exponent",          0, 0, 24'h900000, 0, 0, 0, 300, 2'b01);
    drive("R8 max finite",              0, 0, 24'hFFFFFF, 0, 0, 0, 254, 2'b00);
    drive("R9 cancel underflow",        1, 0, 24'h000001, 0, 0, 0, 10, 2'b00);
    drive("R9 sticky only",             0, 0, 24'h000000, 0, 0, 1, 127, 2'b10);
    drive("R9 exponent zero",           0, 0, 24'h800000, 0, 0, 0, 0, 2'b00);
    drive("R9 negative exponent",       1, 0, 24'h800000, 0, 0, 0, -40, 2'b00);
    drive("R9 smallest normal",         0, 0, 24'h800000, 0, 0, 0, 1, 2'b00);
    drive("R10 zero nearest",           1, 0, 24'h000000, 0, 0, 0, 127, 2'b00);
    drive("R10 zero up",                1, 0, 24'h000000, 0, 0, 0, 127, 2'b10);
    drive("R10 zero down",              0, 0, 24'h000000, 0, 0, 0, 127, 2'b11);

    for (int n = 0; n < 300; n++) begin
      drive("R12 random mix", 1'($urandom), 1'($urandom), 24'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(0, 300), 2'($urandom));
    end
    for (int n = 0; n < 100; n++) begin
      drive("R3 random cancel", 1'($urandom), 1'b0, 24'($urandom) >> $urandom_range(0, 24),
            1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(1, 200), 2'($urandom));
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing outputs got=%0d pending exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired got=hang exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule